// File: doc/BRIEF.md
# LCD Refresh Scanner with Programmable Start Line

This block runs the refresh of a 136 by 34 dot-matrix panel driven at 1/34 duty. A divided oscillator supplies a one-clock tick. A fixed number of ticks makes one line period. In each line period the block fetches one 136-pixel row from the display RAM and holds it for the column drivers. It also moves a single active row strobe down the panel.

The RAM row address does not start at zero. It begins at a programmable start line and wraps past row 33, so software scrolls the picture vertically by changing one value. A new start line is used only from the next frame. At each frame start a polarity bit flips, and every column and row output carries that bit beside its data or strobe so that external circuits can pick the drive level.

Blanking clears the held row rather than the RAM. Standby freezes the scan and drives every output code inactive.

Top module: `lcd_refresh_scanner`

## Requirements
- R1: While reset is asserted and after it is released, before any tick, ramRdEn is 0, ramRowAddr is 0, colOut is all zeros, rowOut is all zeros and frameInv is 0.
- R2: A line period is TICKS_PER_LINE ticks, counted 0 to TICKS_PER_LINE-1. The tick numbered TICKS_PER_LINE-2 raises ramRdEn for exactly the next clock. The tick numbered TICKS_PER_LINE-1 updates the held row and the row strobe in the next clock.
- R3: With start line S, successive reads visit RAM rows S, S+1, ..., 33, 0, ..., S-1, and then S again.
- R4: The row strobe is one-hot across 34 rows, or all zero before the first line is loaded. It moves one row per line and sits on panel row 0 for the line that was read from RAM row S.
- R5: The start line is sampled only when the read for panel row 0 is issued. A change in the middle of a frame first shows in the next frame.
- R6: frameInv flips each time the row strobe is loaded onto panel row 0. colOut bits [2c+1:2c] hold {frameInv, column c data}, and rowOut bits [2r+1:2r] hold {frameInv, row r strobe}.
- R7: A held column bit equals the RAM bit that was read for that line. A value of 1 means the pixel is on.
- R8: While displayOn is 0, the held column data is zero from the next clock onward. The RAM is not touched, so the next line loaded after displayOn returns to 1 again shows RAM data.
- R9: While standby is 1, colOut and rowOut are all zeros in that same cycle and ticks are ignored. When standby returns to 0, the scan continues from where it stopped.
- R10: A start line value of 34 or more is used as 0.
- R11: Ticks come at least two clocks apart. ramRowData is sampled on the line-update tick and may arrive any time between the read pulse and that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| oscTick | input | 1 | One-clock tick from the divided oscillator |
| startLine | input | 6 | RAM row shown on the top panel row |
| displayOn | input | 1 | 1 shows RAM data, 0 blanks the columns |
| standby | input | 1 | Freezes the scan and forces the outputs inactive |
| ramRowData | input | 136 | Row returned by the display RAM |
| ramRdEn | output | 1 | One-clock RAM row read request |
| ramRowAddr | output | 6 | RAM row address for the read |
| colOut | output | 272 | Per column {frameInv, pixel} code |
| rowOut | output | 68 | Per row {frameInv, strobe} code |
| frameInv | output | 1 | Frame polarity bit |

## Verification
The embedded properties check, on every clock, that the row strobe stays one-hot, that the address stays below 34, that the read pulse lasts a single clock, that blanking clears the held row one clock after the display turns off, that polarity changes only when row 0 is loaded, and that standby freezes the tick and line counters.

Only the bench's scenarios can show the following:
- the wrapped address order for several start lines, including 33 and out-of-range values;
- the start line waiting for the frame boundary;
- pixel data returning after a blank period;
- the scan resuming correctly after standby;
- correct behaviour when ticks arrive at uneven spacing.

The bench shows these by comparing every output against a behavioural model on every clock.

// File: rtl/lcd_scan_pkg.sv
`timescale 1ns/1ps
package lcd_scan_pkg;
  // strobes from the line sequencer to the datapath
  typedef struct packed {
    logic issueRead;   // fetch the row for the coming line
    logic latchLine;   // load row data and advance the strobe
    logic frameHead;   // the coming line is panel row 0
  } scanStrobeT;
endpackage

// File: rtl/lcd_scan_ctrl.sv
`timescale 1ns/1ps
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int TICKS_PER_LINE = 4,
  parameter int NUM_ROWS       = 34
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscTick,
  input  logic       standby,
  output scanStrobeT strobe
);
  localparam int TW = (TICKS_PER_LINE > 2) ? $clog2(TICKS_PER_LINE) : 1;
  localparam int RW = $clog2(NUM_ROWS);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_LINE - 1);
  localparam logic [TW-1:0] TICK_READ = TW'(TICKS_PER_LINE - 2);
  localparam logic [RW-1:0] ROW_LAST  = RW'(NUM_ROWS - 1);

  logic [TW-1:0] tickCnt;
  logic [RW-1:0] nextLine;
  logic          tickLive;

  assign tickLive = oscTick && !standby;

  always_comb begin
    strobe.issueRead = tickLive && (tickCnt == TICK_READ);
    strobe.latchLine = tickLive && (tickCnt == TICK_LAST);
    strobe.frameHead = (nextLine == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (tickLive) begin
      tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextLine <= '0;
    end else if (strobe.latchLine) begin
      nextLine <= (nextLine == ROW_LAST) ? '0 : nextLine + 1'b1;
    end
  end

  assert_tick_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= TICK_LAST);

  assert_line_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    nextLine <= ROW_LAST);

  assert_standby_tick_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> $stable(tickCnt));

  assert_standby_line_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> $stable(nextLine));
endmodule

// File: rtl/lcd_scan_shift.sv
`timescale 1ns/1ps
module lcd_scan_shift #(
  parameter int LEN = 17
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           shiftEn,
  input  logic           serIn,
  output logic [LEN-1:0] taps
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      taps <= '0;
    end else if (shiftEn) begin
      taps <= {taps[LEN-2:0], serIn};
    end
  end
endmodule

// File: rtl/lcd_scan_datapath.sv
`timescale 1ns/1ps
module lcd_scan_datapath
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COLS = 136,
  parameter int NUM_ROWS = 34,
  parameter int NUM_SEGS = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  scanStrobeT                  strobe,
  input  logic [$clog2(NUM_ROWS)-1:0] startLine,
  input  logic                        displayOn,
  input  logic [NUM_COLS-1:0]         ramRowData,
  output logic                        ramRdEn,
  output logic [$clog2(NUM_ROWS)-1:0] ramRowAddr,
  output logic [NUM_COLS-1:0]         colData,
  output logic [NUM_ROWS-1:0]         rowSel,
  output logic                        frameInv
);
  localparam int RW      = $clog2(NUM_ROWS);
  localparam int SEG_LEN = NUM_ROWS / NUM_SEGS;
  localparam logic [RW-1:0] ROW_LAST = RW'(NUM_ROWS - 1);

  logic [RW-1:0] startSafe;
  logic [NUM_SEGS-1:0][SEG_LEN-1:0] segTaps;
  logic [NUM_SEGS-1:0] segIn;

  assign startSafe = (startLine <= ROW_LAST) ? startLine : '0;

  // read address: reloaded at the frame head, then wraps upward
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramRowAddr <= '0;
      ramRdEn    <= 1'b0;
    end else begin
      ramRdEn <= strobe.issueRead;
      if (strobe.issueRead) begin
        if (strobe.frameHead)
          ramRowAddr <= startSafe;
        else
          ramRowAddr <= (ramRowAddr == ROW_LAST) ? '0 : ramRowAddr + 1'b1;
      end
    end
  end

  // held row: blanking clears the latch, never the RAM
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colData <= '0;
    end else if (!displayOn) begin
      colData <= '0;
    end else if (strobe.latchLine) begin
      colData <= ramRowData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameInv <= 1'b0;
    end else if (strobe.latchLine && strobe.frameHead) begin
      frameInv <= !frameInv;
    end
  end

  // row strobe chain built from equal segments
  generate
    for (genvar s = 0; s < NUM_SEGS; s++) begin : gSeg
      if (s == 0) begin : gHead
        assign segIn[s] = strobe.frameHead;
      end else begin : gLink
        assign segIn[s] = segTaps[s-1][SEG_LEN-1];
      end
      lcd_scan_shift #(.LEN(SEG_LEN)) uSeg (
        .clk    (clk),
        .rstN   (rstN),
        .shiftEn(strobe.latchLine),
        .serIn  (segIn[s]),
        .taps   (segTaps[s])
      );
    end
  endgenerate

  assign rowSel = segTaps;

  assert_rowsel_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowSel));

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    ramRowAddr <= ROW_LAST);

  assert_read_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    ramRdEn |=> !ramRdEn);

  assert_blank_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !displayOn |=> (colData == '0));

  assert_inv_at_head_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(frameInv) |-> rowSel[0]);
endmodule

// File: rtl/lcd_refresh_scanner.sv
`timescale 1ns/1ps
module lcd_refresh_scanner
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COLS       = 136,
  parameter int NUM_ROWS       = 34,
  parameter int TICKS_PER_LINE = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        oscTick,
  input  logic [$clog2(NUM_ROWS)-1:0] startLine,
  input  logic                        displayOn,
  input  logic                        standby,
  input  logic [NUM_COLS-1:0]         ramRowData,
  output logic                        ramRdEn,
  output logic [$clog2(NUM_ROWS)-1:0] ramRowAddr,
  output logic [2*NUM_COLS-1:0]       colOut,
  output logic [2*NUM_ROWS-1:0]       rowOut,
  output logic                        frameInv
);
  scanStrobeT          strobe;
  logic [NUM_COLS-1:0] colData;
  logic [NUM_ROWS-1:0] rowSel;

  lcd_scan_ctrl #(
    .TICKS_PER_LINE(TICKS_PER_LINE),
    .NUM_ROWS      (NUM_ROWS)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .oscTick(oscTick),
    .standby(standby),
    .strobe (strobe)
  );

  lcd_scan_datapath #(
    .NUM_COLS(NUM_COLS),
    .NUM_ROWS(NUM_ROWS),
    .NUM_SEGS(2)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startLine (startLine),
    .displayOn (displayOn),
    .ramRowData(ramRowData),
    .ramRdEn   (ramRdEn),
    .ramRowAddr(ramRowAddr),
    .colData   (colData),
    .rowSel    (rowSel),
    .frameInv  (frameInv)
  );

  generate
    for (genvar c = 0; c < NUM_COLS; c++) begin : gCol
      assign colOut[2*c+1 -: 2] = standby ? 2'b00 : {frameInv, colData[c]};
    end
    for (genvar r = 0; r < NUM_ROWS; r++) begin : gRow
      assign rowOut[2*r+1 -: 2] = standby ? 2'b00 : {frameInv, rowSel[r]};
    end
  endgenerate
endmodule

// File: tb/lcd_refresh_scanner_test.sv
`timescale 1ns/1ps
module lcd_refresh_scanner_test;
  localparam int COLS = 136;
  localparam int ROWS = 34;
  localparam int TPL  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscTick = 1'b0;
  logic [5:0] startLine = '0;
  logic displayOn = 1'b0;
  logic standby = 1'b0;
  logic [COLS-1:0] ramRowData = '0;
  logic ramRdEn;
  logic [5:0] ramRowAddr;
  logic [2*COLS-1:0] colOut;
  logic [2*ROWS-1:0] rowOut;
  logic frameInv;

  int checks = 0;
  int fails = 0;
  bit compareOn = 0;
  bit done = 0;
  string addrTag = "R3";
  string colTag = "R7";

  always #2.5 clk = ~clk;

  lcd_refresh_scanner #(.NUM_COLS(COLS), .NUM_ROWS(ROWS), .TICKS_PER_LINE(TPL)) uut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .startLine(startLine),
    .displayOn(displayOn), .standby(standby), .ramRowData(ramRowData),
    .ramRdEn(ramRdEn), .ramRowAddr(ramRowAddr), .colOut(colOut),
    .rowOut(rowOut), .frameInv(frameInv));

  function automatic logic [COLS-1:0] pat(int r);
    logic [COLS-1:0] v;
    for (int c = 0; c < COLS; c++)
      v[c] = ((((c * 7) + (r * 3)) % 5) == 0) ^ (c == r);
    return v;
  endfunction

  // RAM: one clock after the read request
  always @(posedge clk) if (ramRdEn) ramRowData <= pat(int'(ramRowAddr));

  // behavioural reference
  int mTick, mNext, mAddr, mRow;
  bit mRd, mInv;
  logic [COLS-1:0] mData;

  always @(posedge clk) begin
    if (!rstN) begin
      mTick = 0; mNext = 0; mAddr = 0; mRow = -1; mRd = 0; mInv = 0; mData = '0;
    end else begin
      mRd = 0;
      if (oscTick && !standby) begin
        if (mTick == TPL - 2) begin
          mRd = 1;
          if (mNext == 0) mAddr = (startLine < ROWS) ? int'(startLine) : 0;
          else mAddr = (mAddr + 1) % ROWS;
        end
        if (mTick == TPL - 1) begin
          if (displayOn) mData = pat(mAddr);
          mRow = mNext;
          if (mNext == 0) mInv = !mInv;
          mNext = (mNext + 1) % ROWS;
        end
        mTick = (mTick + 1) % TPL;
      end
      if (!displayOn) mData = '0;
    end
  end

  task automatic check(string tag, string what, logic [2*COLS-1:0] act, logic [2*COLS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rstN && compareOn && !done) begin
      logic [2*COLS-1:0] eCol;
      logic [2*ROWS-1:0] eRow;
      for (int c = 0; c < COLS; c++)
        eCol[2*c+1 -: 2] = standby ? 2'b00 : {mInv, mData[c]};
      for (int r = 0; r < ROWS; r++)
        eRow[2*r+1 -: 2] = standby ? 2'b00 : {mInv, (r == mRow)};
      check("R2", "ramRdEn", ramRdEn, mRd);
      check(addrTag, "ramRowAddr", ramRowAddr, mAddr[5:0]);
      check("R6", "frameInv", frameInv, mInv);
      check(standby ? "R9" : "R4", "rowOut", rowOut, eRow);
      check(standby ? "R9" : (!displayOn ? "R8" : colTag), "colOut", colOut, eCol);
    end
  end

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) oscTick = 1'b1;
      @(negedge clk) oscTick = 1'b0;
      repeat (gap - 2) @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    check("R1", "reset colOut", colOut, '0);
    check("R1", "reset rowOut", rowOut, '0);
    check("R1", "reset addr/rd/inv", {ramRowAddr, ramRdEn, frameInv}, '0);
    @(negedge clk) rstN = 1'b1;
    compareOn = 1;
    @(posedge clk); #1;
    check("R1", "post-reset rowOut", rowOut, '0);
    // plain scan from row 0
    @(negedge clk) displayOn = 1'b1;
    ticks(40, 3);
    ticks(ROWS * TPL, 3);
    // start line changed in the middle of a frame
    addrTag = "R5";
    ticks(20, 3);
    startLine = 6'd16;
    ticks(2 * ROWS * TPL, 3);
    startLine = 6'd33;
    ticks(ROWS * TPL + 10, 3);
    // out-of-range start line
    addrTag = "R10";
    startLine = 6'd45;
    ticks(2 * ROWS * TPL, 3);
    addrTag = "R3";
    startLine = 6'd5;
    // blanking and recovery
    displayOn = 1'b0;
    ticks(30, 3);
    displayOn = 1'b1;
    ticks(20, 3);
    // standby in the middle of a line
    ticks(2, 3);
    standby = 1'b1;
    ticks(5, 3);
    standby = 1'b0;
    ticks(40, 3);
    // uneven tick spacing
    colTag = "R11";
    for (int k = 0; k < 30; k++) begin
      ticks(1, 2);
      ticks(1, 5);
    end
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule